// File: doc/BRIEF.md
# Clock Source and Wait-Mode Controller

This block holds the control and status logic of a clock generator. Each cycle it picks one of three clock enables to pass on as the system clock enable: one derived from the oscillator, one from the PLL, or one from the PLL running at its lowest frequency. It also produces a bus clock enable at half the system rate. The analog PLL, the oscillator and the clock monitor are outside the block. They appear only as enable pulses, a lock level and a failure level.

Software drives the block through a four-entry byte register interface. The interface holds control bits, wait-mode options, sticky change flags and interrupt enables. The block applies forced bit changes when the core enters wait mode. It also reacts to an oscillator failure, either by switching to self-clock mode or by requesting a reset.

Top module: `clkgen_ctrl`

## Requirements
- R1: The control register (address 0) uses bit 0 to select the PLL. When bit 0 is 1, `sys_ce` follows `pll_tick`. When it is 0, `sys_ce` follows `osc_tick`. This holds outside wait gating and outside self-clock mode.
- R2: `bus_ce` pulses together with every second `sys_ce` pulse. The first pulse is on the second `sys_ce` after reset. `bus_ce` is never high on two consecutive cycles.
- R3: The wait register (address 1) uses bit 0 as the PLL-stop option. If this bit is 1 when `wait_req` rises, PLL select (address 0 bit 0) is cleared and the stored automatic-bandwidth bit (address 0 bit 1) is set, on the same edge at which wait starts. Leaving wait does not restore PLL select.
- R4: While address 1 bit 0 is 1, address 0 bit 1 reads as 1.
- R5: The lock flag (address 2 bit 0) is set on the third rising edge after `lock_in` changes, in either direction. The synchronized lock level reads at address 2 bit 4.
- R6: Self-clock mode starts when all of these hold: monitor enable (address 0 bit 2) is 1, self-clock enable (address 0 bit 3) is 1, and `osc_fail` is high. In this mode the status bit (address 2 bit 5) is 1 and `sys_ce` follows `pll_min_tick`, whatever PLL select says. The mode lasts until reset. Entering it sets the self-clock flag (address 2 bit 1).
- R7: `reset_req` is high while monitor enable is 1, the synchronized `osc_fail` is high, self-clock enable is 0, and the block is not in self-clock mode.
- R8: While monitor enable is 0, `osc_fail` has no effect. `reset_req` stays 0 and the self-clock status stays 0.
- R9: Writing 1 to a flag bit at address 2 clears that flag. Writing 0 leaves it unchanged. If a set event and a clear write arrive on the same edge, the flag stays set.
- R10: `irq` is high when the lock flag and its enable (address 3 bit 0) are both 1, or when the self-clock flag and its enable (address 3 bit 1) are both 1.
- R11: During wait, with system-stop (address 1 bit 1) set, `sys_ce`, `bus_ce` and `core_ce` are all 0. During wait, with only core-stop (address 1 bit 2) set, `core_ce` is 0 while `sys_ce` still runs.
- R12: After reset, every register reads 0 and `irq` and `reset_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_tick | input | 1 | Oscillator-derived clock enable |
| pll_tick | input | 1 | PLL-derived clock enable |
| pll_min_tick | input | 1 | Enable from the PLL at its minimum frequency |
| lock_in | input | 1 | Asynchronous PLL lock level |
| osc_fail | input | 1 | Asynchronous oscillator failure level from the monitor |
| wait_req | input | 1 | Core is in wait mode |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| sys_ce | output | 1 | System clock enable |
| bus_ce | output | 1 | Bus clock enable (half rate) |
| core_ce | output | 1 | Core clock enable |
| irq | output | 1 | Interrupt request |
| reset_req | output | 1 | Reset request after an unhandled oscillator failure |

## Verification
The embedded assertions check several rules on every cycle. `bus_ce` never appears on two consecutive cycles. Self-clock mode, once entered, persists. A flag drops only after a write of 1 to its bit. `reset_req` requires monitor enable. Wait entry with the PLL-stop option leaves PLL select cleared. Other behaviours can only be shown by the bench's scenarios: which tick source `sys_ce` follows under random enable patterns, the exact three-edge latency of the lock flag, the persistence of the cleared PLL select after waking, and the difference between system-stop and core-stop gating.

// File: rtl/clkgen_ctrl.sv
module clkgen_ctrl #(
  parameter int DW = 8,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          osc_tick,
  input  logic          pll_tick,
  input  logic          pll_min_tick,
  input  logic          lock_in,
  input  logic          osc_fail,
  input  logic          wait_req,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          sys_ce,
  output logic          bus_ce,
  output logic          core_ce,
  output logic          irq,
  output logic          reset_req
);
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_WAIT = AW'(1);
  localparam logic [AW-1:0] A_FLAG = AW'(2);
  localparam logic [AW-1:0] A_IEN  = AW'(3);

  logic use_pll, auto_bw, mon_en, scm_en;
  logic pll_stop, sys_stop, core_stop;
  logic lock_flag, scm_flag, lock_ie, scm_ie;
  logic lock_s1, lock_s2, lock_q;
  logic fail_s1, fail_s2;
  logic scm, scm_q, in_wait, phase;
  logic src_tick, wait_entry, scm_hit;

  assign wait_entry = wait_req & ~in_wait;
  assign scm_hit    = mon_en & fail_s2 & scm_en;
  assign src_tick   = scm ? pll_min_tick : (use_pll ? pll_tick : osc_tick);
  assign sys_ce     = src_tick & ~(in_wait & sys_stop);
  assign bus_ce     = sys_ce & phase;
  assign core_ce    = sys_ce & ~(in_wait & core_stop);
  assign irq        = (lock_flag & lock_ie) | (scm_flag & scm_ie);
  assign reset_req  = mon_en & fail_s2 & ~scm_en & ~scm;

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL:  rdata[3:0] = {scm_en, mon_en, auto_bw | pll_stop, use_pll};
      A_WAIT:  rdata[2:0] = {core_stop, sys_stop, pll_stop};
      A_FLAG:  begin rdata[5:4] = {scm, lock_s2}; rdata[1:0] = {scm_flag, lock_flag}; end
      default: rdata[1:0] = {scm_ie, lock_ie};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {lock_s1, lock_s2, lock_q, fail_s1, fail_s2} <= '0;
      {scm, scm_q, in_wait, phase} <= '0;
    end else begin
      lock_s1 <= lock_in;
      lock_s2 <= lock_s1;
      lock_q  <= lock_s2;
      fail_s1 <= osc_fail;
      fail_s2 <= fail_s1;
      scm     <= scm | scm_hit;
      scm_q   <= scm;
      in_wait <= wait_req;
      if (sys_ce) phase <= ~phase;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {use_pll, auto_bw, mon_en, scm_en} <= '0;
      {pll_stop, sys_stop, core_stop} <= '0;
      {lock_flag, scm_flag, lock_ie, scm_ie} <= '0;
    end else begin
      if (wr_en && addr == A_CTRL) {scm_en, mon_en, auto_bw, use_pll} <= wdata[3:0];
      if (wr_en && addr == A_WAIT) {core_stop, sys_stop, pll_stop} <= wdata[2:0];
      if (wr_en && addr == A_IEN)  {scm_ie, lock_ie} <= wdata[1:0];
      if (wr_en && addr == A_FLAG) begin
        if (wdata[0]) lock_flag <= 1'b0;
        if (wdata[1]) scm_flag  <= 1'b0;
      end
      if (lock_s2 != lock_q) lock_flag <= 1'b1;
      if (scm != scm_q)      scm_flag  <= 1'b1;
      if (wait_entry && pll_stop) begin
        use_pll <= 1'b0;
        auto_bw <= 1'b1;
      end
    end
  end

  assert_bus_half_rate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ce |=> !bus_ce);
  assert_wait_drops_pll_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_req && !in_wait && pll_stop) |=> (!use_pll && auto_bw));
  assert_scm_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    scm |=> scm);
  assert_rst_needs_monitor_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> mon_en);
  assert_lockflag_w1c_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_flag) |-> $past(wr_en && addr == A_FLAG && wdata[0]));
  assert_scmflag_w1c_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scm_flag) |-> $past(wr_en && addr == A_FLAG && wdata[1]));
endmodule

// File: tb/clkgen_ctrl_bench.sv
module clkgen_ctrl_bench;
  logic clk = 0, rst_n = 0;
  logic osc_tick = 0, pll_tick = 0, pll_min_tick = 0, lock_in = 0, osc_fail = 0, wait_req = 0;
  logic wr_en = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic sys_ce, bus_ce, core_ce, irq, reset_req;
  int tests = 0, fails = 0;
  bit done = 0;
  logic exp_phase = 0;

  always #4 clk = ~clk;

  clkgen_ctrl u_clkgen_ctrl (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  function automatic bit exp_src(input bit sel, input bit o, input bit p);
    return sel ? p : o;
  endfunction

  task automatic rand_run(input bit sel, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      osc_tick = 1'($urandom); pll_tick = 1'($urandom); pll_min_tick = 1'($urandom);
      #1;
      chk(sys_ce == exp_src(sel, osc_tick, pll_tick), "R1 sys_ce source", sys_ce,
          exp_src(sel, osc_tick, pll_tick));
      chk(bus_ce == (sys_ce & exp_phase), "R2 bus_ce half rate", bus_ce, sys_ce & exp_phase);
      if (sys_ce) exp_phase = ~exp_phase;
    end
    @(negedge clk); osc_tick = 0; pll_tick = 0; pll_min_tick = 0;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'h5eed_c10c));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      chk(d == 0, "R12 reset reg", d, 0);
    end
    chk(irq == 0 && reset_req == 0, "R12 reset outputs", {irq, reset_req}, 0);

    // R1, R2 random tick patterns, both sources
    rand_run(0, 150);
    wr(0, 8'h01);
    rand_run(1, 150);

    // R4 auto bit forced readback, R3 wait entry
    wr(1, 8'h01);
    rd(0, d);
    chk(d[1:0] == 2'b11, "R4 auto reads 1 with pll-stop", d[1:0], 3);
    @(negedge clk); wait_req = 1;
    @(negedge clk); @(negedge clk);
    rd(0, d);
    chk(d[0] == 0, "R3 pll select cleared in wait", d[0], 0);
    wait_req = 0;
    repeat (3) @(negedge clk);
    rd(0, d);
    chk(d[0] == 0, "R3 pll select stays clear after wake", d[0], 0);
    wr(1, 8'h00);
    rd(0, d);
    chk(d[1] == 1, "R3 auto bit stored as 1", d[1], 1);
    wr(0, 8'h00);

    // R11 wait gating
    wr(1, 8'h02);
    @(negedge clk); osc_tick = 1; #1;
    chk(sys_ce == 1, "R11 sys_ce before wait", sys_ce, 1);
    wait_req = 1;
    @(negedge clk); #1;
    chk({sys_ce, bus_ce, core_ce} == 0, "R11 system-stop gates all", {sys_ce, bus_ce, core_ce}, 0);
    wait_req = 0;
    wr(1, 8'h04);
    @(negedge clk); wait_req = 1;
    @(negedge clk); #1;
    chk(sys_ce == 1 && core_ce == 0, "R11 core-stop gates core only", {sys_ce, core_ce}, 2);
    wait_req = 0; osc_tick = 0;
    wr(1, 8'h00);

    // R5 lock flag latency, R10 irq, R9 w1c
    @(negedge clk); lock_in = 1;
    @(negedge clk); @(negedge clk);
    rd(2, d);
    chk(d[0] == 0, "R5 lock flag not before third edge", d[0], 0);
    @(negedge clk);
    rd(2, d);
    chk(d[0] == 1 && d[4] == 1, "R5 lock flag on rise", d, 8'h11);
    chk(irq == 0, "R10 no irq while disabled", irq, 0);
    wr(3, 8'h01); #1;
    chk(irq == 1, "R10 irq with lock enable", irq, 1);
    wr(2, 8'h02);
    rd(2, d);
    chk(d[0] == 1, "R9 write 0 keeps lock flag", d[0], 1);
    wr(2, 8'h01);
    rd(2, d);
    chk(d[0] == 0 && irq == 0, "R9 write 1 clears lock flag", d[0], 0);
    @(negedge clk); lock_in = 0;
    repeat (3) @(negedge clk);
    rd(2, d);
    chk(d[0] == 1 && d[4] == 0, "R5 lock flag on fall", d, 8'h01);
    // R9 set beats clear: toggle lock so set coincides with clear write
    @(negedge clk); lock_in = 1; wr_en = 1; addr = 2; wdata = 8'h01;
    @(negedge clk); wdata = 8'h00; wr_en = 0;
    @(negedge clk); wr_en = 1; wdata = 8'h01;
    @(negedge clk); wr_en = 0; wdata = 0;
    rd(2, d);
    chk(d[0] == 1, "R9 set wins over clear", d[0], 1);
    wr(2, 8'h01);
    wr(3, 8'h00);

    // R8 monitor disabled
    osc_fail = 1;
    repeat (4) @(negedge clk);
    rd(2, d);
    chk(reset_req == 0 && d[5] == 0, "R8 fail ignored when monitor off", {reset_req, d[5]}, 0);
    // R7 reset request
    wr(0, 8'h04); #1;
    chk(reset_req == 1, "R7 reset request", reset_req, 1);
    osc_fail = 0;
    repeat (3) @(negedge clk); #1;
    chk(reset_req == 0, "R7 request drops with fail", reset_req, 0);

    // R6 self-clock mode
    wr(0, 8'h0D);
    wr(3, 8'h02);
    osc_fail = 1;
    repeat (5) @(negedge clk);
    osc_fail = 0;
    rd(2, d);
    chk(d[5] == 1 && d[1] == 1, "R6 self-clock status and flag", d[5:4], 2);
    chk(irq == 1 && reset_req == 0, "R6 irq, no reset", {irq, reset_req}, 2);
    repeat (4) @(negedge clk);
    rd(2, d);
    chk(d[5] == 1, "R6 self-clock sticky", d[5], 1);
    pll_tick = 1; osc_tick = 1; pll_min_tick = 0; #1;
    chk(sys_ce == 0, "R6 ignores pll select", sys_ce, 0);
    @(negedge clk); pll_min_tick = 1; pll_tick = 0; osc_tick = 0; #1;
    chk(sys_ce == 1, "R6 follows minimum PLL tick", sys_ce, 1);
    pll_min_tick = 0;

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule